// File: doc/BRIEF.md
# AHCI Channel Register Bank with Interrupt

This block is the register bank of one command channel of a disk host controller that follows the AHCI software model. Software programs it through a 32-bit register port inside a 4 KB window. It holds the 64-bit base address of the command list, the command-issue bit-vector, the channel run bit, and the interrupt status and enable registers. It drives one registered interrupt line.

The command-list walker sits next to the block and uses it in two ways. It reads the list base, the polling enable and the vector of posted slots. It returns one clear pulse for each finished slot, plus completion and error events; an error event carries the index of the faulty slot and of the faulty buffer. The issue vector accumulates software writes by OR. Any write to the status register wipes it. Writing zero to the run register soft-resets the issue, status, enable and run registers. The list base is not affected by that soft reset.

Each channel owns a 4 KB window, and the full controller segment must be 32 KB aligned. The bus adapter and the DMA engine are outside this block. Reads are combinational from the offset. Writes take effect at the clock edge that samples the write strobe.

Top module: `ahci_chan_regs`

## Requirements
- R1: After reset every register reads 0, `list_base_o` is 0, `issue_pend_o` is 0, `poll_en_o` is 0 and `irq_o` is 0.
- R2: The register map uses these byte offsets: list base low at 0x000, list base high at 0x004, issue at 0x008, run at 0x00C, status at 0x010 and enable at 0x014. A write to list base low stores the data with bits 3:0 forced to 0. List base high stores all 32 bits. `list_base_o` is {high, low}.
- R3: A write to the issue register (0x008) sets its new value to the OR of the old value and the write data.
- R4: A 1 on bit n of `slot_clr_i` clears issue bit n at that clock edge. If a software write sets the same bit in the same cycle, the set wins. `issue_pend_o` always equals the issue register.
- R5: A `done_evt_i` pulse sets status bit 0. An `err_evt_i` pulse sets status bit 30 and captures `err_slot_i` into bits 28:24 and `err_buf_i` into bits 23:8. While bit 30 is set, later errors leave those fields unchanged. Status bits 31, 29 and 7:1 always read 0.
- R6: Any write to the status register (0x010) clears all of its bits, whatever the write data. An event in the same cycle is applied after the clear.
- R7: The enable register (0x014) stores only bits 0 and 30. All other bits read 0.
- R8: `irq_o` is a register. It is 1 in the cycle after (status bit 0 AND enable bit 0) OR (status bit 30 AND enable bit 30) is true, and 0 in the cycle after that condition is false.
- R9: Writing a nonzero value to the run register (0x00C) makes it read 1 and enables polling. Writing 0 clears the issue, status, enable and run registers and leaves the list base unchanged.
- R10: `poll_en_o` is the run bit masked by the error flag. It is 0 while status bit 30 is set and comes back once the status is cleared.
- R11: Writes to offsets outside the map change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte offset inside the channel window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| list_base_o | output | 64 | Command-list base address |
| poll_en_o | output | 1 | Walker may poll the command list |
| issue_pend_o | output | SLOTS | Posted-command vector |
| slot_clr_i | input | SLOTS | Per-slot completion clear pulses |
| done_evt_i | input | 1 | Command completed event |
| err_evt_i | input | 1 | Command error event |
| err_slot_i | input | SLOT_IDX_W | Faulty slot index |
| err_buf_i | input | BUF_IDX_W | Faulty buffer index |
| irq_o | output | 1 | Channel interrupt |

## Verification
The bench builds the block with its default parameters: 32 slots and a 16-bit buffer index. With those values every status field is filled to its full width. Issue bit 31 can be set and cleared, and an error capture fills all of bits 28:8. A table of register writes and reads covers the map, alignment, the OR accumulation and the soft reset. Directed steps then cover the set-versus-clear race, the one-cycle interrupt latency, first-error retention and a status clear that coincides with a new event.

// File: rtl/ahci_chan_pkg.sv
package ahci_chan_pkg;

  localparam int WORD_W = 32;
  localparam int OFS_W  = 12;

  // Fixed field positions of the status word.
  localparam int ST_DONE   = 0;
  localparam int ST_ERR    = 30;
  localparam int ST_SLOT_L = 24;
  localparam int ST_BUF_L  = 8;
  localparam int ST_SLOT_W = 5;
  localparam int ST_BUF_W  = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BASE_LO,
    SEL_BASE_HI,
    SEL_ISSUE,
    SEL_RUN,
    SEL_STAT,
    SEL_EN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs[OFS_W-1:2])
      10'd0:   sel = SEL_BASE_LO;
      10'd1:   sel = SEL_BASE_HI;
      10'd2:   sel = SEL_ISSUE;
      10'd3:   sel = SEL_RUN;
      10'd4:   sel = SEL_STAT;
      10'd5:   sel = SEL_EN;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/ahci_list_base.sv
module ahci_list_base #(
  parameter int W          = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);

  logic [W-1:0] lo_q, lo_d;
  logic [W-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = wdata_i;
    lo_d[ALIGN_BITS-1:0] = '0;
    hi_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo_i) lo_q <= lo_d;
      if (wr_hi_i) hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q[ALIGN_BITS-1:0] == '0); // R2

  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi_i |=> $stable(hi_q)); // R9

endmodule

// File: rtl/ahci_issue_vec.sv
module ahci_issue_vec #(
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set_i,
  input  logic             soft_clr_i,
  input  logic [SLOTS-1:0] wdata_i,
  input  logic [SLOTS-1:0] hw_clr_i,
  output logic [SLOTS-1:0] pend_o
);

  logic [SLOTS-1:0] pend_q, pend_d, set_mask;
  logic             upd;

  always_comb begin
    set_mask = wr_set_i ? wdata_i : '0;
    upd      = wr_set_i | soft_clr_i | (|hw_clr_i);
    if (soft_clr_i) pend_d = '0;
    else            pend_d = (pend_q & ~hw_clr_i) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set_i && !soft_clr_i) |=> ((pend_q & $past(wdata_i)) == $past(wdata_i))); // R3

  AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_clr_i & ~set_mask)) |=> ((pend_q & $past(hw_clr_i & ~set_mask)) == '0)); // R4

  AST_SOFT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr_i |=> (pend_q == '0)); // R9

endmodule

// File: rtl/ahci_int_ctrl.sv
module ahci_int_ctrl
  import ahci_chan_pkg::*;
#(
  parameter int SLOT_IDX_W = 5,
  parameter int BUF_IDX_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stat_i,
  input  logic                  wr_en_i,
  input  logic                  soft_clr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic                  done_evt_i,
  input  logic                  err_evt_i,
  input  logic [SLOT_IDX_W-1:0] err_slot_i,
  input  logic [BUF_IDX_W-1:0]  err_buf_i,
  output logic [WORD_W-1:0]     stat_o,
  output logic [WORD_W-1:0]     en_o,
  output logic                  err_o,
  output logic                  irq_o
);

  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic [SLOT_IDX_W-1:0] slot_q, slot_d;
  logic [BUF_IDX_W-1:0]  buf_q, buf_d;
  logic                  en_done_q, en_done_d;
  logic                  en_err_q, en_err_d;
  logic                  irq_q, irq_d;
  logic                  wipe, stat_upd, en_upd;

  // Status next state: clear first, then apply this cycle's events.
  always_comb begin
    wipe     = wr_stat_i | soft_clr_i;
    stat_upd = wipe | done_evt_i | err_evt_i;
    done_d   = wipe ? 1'b0 : done_q;
    err_d    = wipe ? 1'b0 : err_q;
    slot_d   = wipe ? '0   : slot_q;
    buf_d    = wipe ? '0   : buf_q;
    if (done_evt_i) done_d = 1'b1;
    if (err_evt_i && !err_d) begin
      err_d  = 1'b1;
      slot_d = err_slot_i;
      buf_d  = err_buf_i;
    end
  end

  always_comb begin
    en_upd    = wr_en_i | soft_clr_i;
    en_done_d = soft_clr_i ? 1'b0 : wdata_i[ST_DONE];
    en_err_d  = soft_clr_i ? 1'b0 : wdata_i[ST_ERR];
    irq_d     = (done_q & en_done_q) | (err_q & en_err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      slot_q    <= '0;
      buf_q     <= '0;
      en_done_q <= 1'b0;
      en_err_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (stat_upd) begin
        done_q <= done_d;
        err_q  <= err_d;
        slot_q <= slot_d;
        buf_q  <= buf_d;
      end
      if (en_upd) begin
        en_done_q <= en_done_d;
        en_err_q  <= en_err_d;
      end
      irq_q <= irq_d;
    end
  end

  // Word assembly with zero padding of the index fields.
  logic [ST_SLOT_W-1:0] slot_f;
  logic [ST_BUF_W-1:0]  buf_f;

  always_comb begin
    slot_f = '0;
    slot_f[SLOT_IDX_W-1:0] = slot_q;
    buf_f = '0;
    buf_f[BUF_IDX_W-1:0] = buf_q;
    stat_o = '0;
    stat_o[ST_DONE] = done_q;
    stat_o[ST_ERR]  = err_q;
    stat_o[ST_SLOT_L +: ST_SLOT_W] = slot_f;
    stat_o[ST_BUF_L  +: ST_BUF_W]  = buf_f;
    en_o = '0;
    en_o[ST_DONE] = en_done_q;
    en_o[ST_ERR]  = en_err_q;
  end

  assign err_o = err_q;
  assign irq_o = irq_q;

  AST_STAT_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat_i && !done_evt_i && !err_evt_i) |=> (stat_o == '0)); // R6

  AST_FIRST_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !wipe) |=> (err_q && $stable(slot_q) && $stable(buf_q))); // R5

  AST_DONE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_i |=> done_q); // R5

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(done_q || err_q)); // R8

endmodule

// File: rtl/ahci_chan_regs.sv
module ahci_chan_regs
  import ahci_chan_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int BUF_IDX_W  = 16,
  parameter int SLOT_IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_i,
  input  logic [OFS_W-1:0]      reg_addr_i,
  input  logic [WORD_W-1:0]     reg_wdata_i,
  output logic [WORD_W-1:0]     reg_rdata_o,
  output logic [2*WORD_W-1:0]   list_base_o,
  output logic                  poll_en_o,
  output logic [SLOTS-1:0]      issue_pend_o,
  input  logic [SLOTS-1:0]      slot_clr_i,
  input  logic                  done_evt_i,
  input  logic                  err_evt_i,
  input  logic [SLOT_IDX_W-1:0] err_slot_i,
  input  logic [BUF_IDX_W-1:0]  err_buf_i,
  output logic                  irq_o
);

  localparam int ALIGN_BITS = 4;

  reg_sel_e          sel;
  logic              wr_lo, wr_hi, wr_issue, wr_run, wr_stat, wr_en;
  logic              soft_clr;
  logic              run_q, run_d, run_upd;
  logic [WORD_W-1:0] base_lo, base_hi, stat_w, en_w, issue_w;
  logic              err_flag;

  always_comb begin
    sel      = decode_ofs(reg_addr_i);
    wr_lo    = reg_wr_i && (sel == SEL_BASE_LO);
    wr_hi    = reg_wr_i && (sel == SEL_BASE_HI);
    wr_issue = reg_wr_i && (sel == SEL_ISSUE);
    wr_run   = reg_wr_i && (sel == SEL_RUN);
    wr_stat  = reg_wr_i && (sel == SEL_STAT);
    wr_en    = reg_wr_i && (sel == SEL_EN);
    soft_clr = wr_run && (reg_wdata_i == '0);
    run_upd  = wr_run;
    run_d    = |reg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (run_upd) run_q <= run_d;
  end

  ahci_list_base #(
    .W          (WORD_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (reg_wdata_i),
    .lo_o    (base_lo),
    .hi_o    (base_hi)
  );

  ahci_issue_vec #(
    .SLOTS (SLOTS)
  ) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_set_i   (wr_issue),
    .soft_clr_i (soft_clr),
    .wdata_i    (reg_wdata_i[SLOTS-1:0]),
    .hw_clr_i   (slot_clr_i),
    .pend_o     (issue_pend_o)
  );

  ahci_int_ctrl #(
    .SLOT_IDX_W (SLOT_IDX_W),
    .BUF_IDX_W  (BUF_IDX_W)
  ) u_int (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stat_i  (wr_stat),
    .wr_en_i    (wr_en),
    .soft_clr_i (soft_clr),
    .wdata_i    (reg_wdata_i),
    .done_evt_i (done_evt_i),
    .err_evt_i  (err_evt_i),
    .err_slot_i (err_slot_i),
    .err_buf_i  (err_buf_i),
    .stat_o     (stat_w),
    .en_o       (en_w),
    .err_o      (err_flag),
    .irq_o      (irq_o)
  );

  always_comb begin
    issue_w = '0;
    issue_w[SLOTS-1:0] = issue_pend_o;
    case (sel)
      SEL_BASE_LO: reg_rdata_o = base_lo;
      SEL_BASE_HI: reg_rdata_o = base_hi;
      SEL_ISSUE:   reg_rdata_o = issue_w;
      SEL_RUN:     reg_rdata_o = {{(WORD_W-1){1'b0}}, run_q};
      SEL_STAT:    reg_rdata_o = stat_w;
      SEL_EN:      reg_rdata_o = en_w;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign list_base_o = {base_hi, base_lo};
  assign poll_en_o   = run_q & ~err_flag;

  AST_POLL_STOPS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> !poll_en_o); // R10

  AST_RUN_ZERO_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!poll_en_o && issue_pend_o == '0 && stat_w == '0 && en_w == '0)
                 || done_evt_i || err_evt_i || $past(done_evt_i || err_evt_i)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (reg_rdata_o == '0)); // R11

endmodule

// File: tb/ahci_chan_regs_bench.sv
module ahci_chan_regs_bench;

  localparam int SLOTS = 32;
  localparam int BUFW  = 16;
  localparam int SW    = 5;

  localparam logic [11:0] A_LO = 12'h000, A_HI = 12'h004, A_ISS = 12'h008,
                          A_RUN = 12'h00C, A_ST = 12'h010, A_EN = 12'h014,
                          A_BAD = 12'h040;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr_i = 1'b0;
  logic [11:0]       reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic [63:0]       list_base_o;
  logic              poll_en_o;
  logic [SLOTS-1:0]  issue_pend_o;
  logic [SLOTS-1:0]  slot_clr_i = '0;
  logic              done_evt_i = 1'b0;
  logic              err_evt_i = 1'b0;
  logic [SW-1:0]     err_slot_i = '0;
  logic [BUFW-1:0]   err_buf_i = '0;
  logic              irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ahci_chan_regs #(.SLOTS(SLOTS), .BUF_IDX_W(BUFW)) u_ahci_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .list_base_o(list_base_o),
    .poll_en_o(poll_en_o), .issue_pend_o(issue_pend_o), .slot_clr_i(slot_clr_i),
    .done_evt_i(done_evt_i), .err_evt_i(err_evt_i), .err_slot_i(err_slot_i),
    .err_buf_i(err_buf_i), .irq_o(irq_o)
  );

  // Vector: {is_write, offset, data, expected read, requirement number}
  localparam int NV = 20;
  localparam logic [84:0] VEC [NV] = '{
    {1'b0, A_LO,  32'h0,         32'h0,         8'd1},  // R1
    {1'b0, A_ST,  32'h0,         32'h0,         8'd1},  // R1
    {1'b1, A_LO,  32'h1234_567F, 32'h0,         8'd2},
    {1'b0, A_LO,  32'h0,         32'h1234_5670, 8'd2},  // R2 alignment
    {1'b1, A_HI,  32'hDEAD_BEEF, 32'h0,         8'd2},
    {1'b0, A_HI,  32'h0,         32'hDEAD_BEEF, 8'd2},  // R2
    {1'b1, A_ISS, 32'h0000_0005, 32'h0,         8'd3},
    {1'b1, A_ISS, 32'h0000_0030, 32'h0,         8'd3},
    {1'b0, A_ISS, 32'h0,         32'h0000_0035, 8'd3},  // R3 OR accumulation
    {1'b1, A_EN,  32'hFFFF_FFFF, 32'h0,         8'd7},
    {1'b0, A_EN,  32'h0,         32'h4000_0001, 8'd7},  // R7
    {1'b1, A_BAD, 32'hFFFF_FFFF, 32'h0,         8'd11},
    {1'b0, A_BAD, 32'h0,         32'h0,         8'd11}, // R11
    {1'b1, A_RUN, 32'h0000_0007, 32'h0,         8'd9},
    {1'b0, A_RUN, 32'h0,         32'h0000_0001, 8'd9},  // R9 nonzero reads 1
    {1'b1, A_RUN, 32'h0,         32'h0,         8'd9},
    {1'b0, A_ISS, 32'h0,         32'h0,         8'd9},  // R9 soft reset
    {1'b0, A_EN,  32'h0,         32'h0,         8'd9},
    {1'b0, A_RUN, 32'h0,         32'h0,         8'd9},
    {1'b0, A_LO,  32'h0,         32'h1234_5670, 8'd9}   // R9 base kept
  };

  task automatic chk(input int req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input int req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, {32'h0, reg_rdata_o}, {32'h0, exp});
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the walker side
    chk(1, list_base_o, 64'h0);
    chk(1, {63'h0, poll_en_o}, 64'h0);
    chk(1, {63'h0, irq_o}, 64'h0);
    chk(1, {32'h0, issue_pend_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) wr(VEC[i][83:72], VEC[i][71:40]);
      else            rd(int'(VEC[i][7:0]), VEC[i][83:72], VEC[i][39:8]);
    end

    chk(2, list_base_o, 64'hDEAD_BEEF_1234_5670); // R2

    // R4 hardware clear and set-wins race, top slot included
    wr(A_ISS, 32'h8000_000F);
    slot_clr_i = 32'h8000_0003; tick(); slot_clr_i = '0;
    rd(4, A_ISS, 32'h0000_000C);
    slot_clr_i = 32'h0000_0006;
    wr(A_ISS, 32'h0000_0004);
    slot_clr_i = '0;
    rd(4, A_ISS, 32'h0000_0008 | 32'h0000_0004);
    chk(4, {32'h0, issue_pend_o}, 64'h0000_000C);

    // R5/R8 completion and registered interrupt
    wr(A_EN, 32'h0000_0001);
    done_evt_i = 1'b1; tick(); done_evt_i = 1'b0;
    rd(5, A_ST, 32'h0000_0001);
    chk(8, {63'h0, irq_o}, 64'h0);
    tick();
    chk(8, {63'h0, irq_o}, 64'h1);
    // R6 write of any data clears the status
    wr(A_ST, 32'h0000_0000);
    rd(6, A_ST, 32'h0);
    chk(8, {63'h0, irq_o}, 64'h1);
    tick();
    chk(8, {63'h0, irq_o}, 64'h0);

    // R5/R10 error capture, first error kept, polling stopped
    wr(A_EN, 32'h4000_0000);
    wr(A_RUN, 32'h0000_0001);
    chk(9, {63'h0, poll_en_o}, 64'h1);
    err_slot_i = 5'd5; err_buf_i = 16'h1234; err_evt_i = 1'b1;
    tick(); err_evt_i = 1'b0;
    rd(5, A_ST, 32'h4512_3400);
    chk(10, {63'h0, poll_en_o}, 64'h0);
    tick();
    chk(8, {63'h0, irq_o}, 64'h1);
    err_slot_i = 5'd7; err_buf_i = 16'h0001; err_evt_i = 1'b1;
    tick(); err_evt_i = 1'b0;
    rd(5, A_ST, 32'h4512_3400);
    // R6 clear with a same-cycle completion event
    done_evt_i = 1'b1;
    wr(A_ST, 32'hFFFF_FFFF);
    done_evt_i = 1'b0;
    rd(6, A_ST, 32'h0000_0001);
    chk(10, {63'h0, poll_en_o}, 64'h1);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0; #1;
    chk(1, {63'h0, irq_o}, 64'h0);
    rd(1, A_ISS, 32'h0);
    rst_n = 1'b1;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule